// File: doc/BRIEF.md
# Mode-Aware Mirrored Video RAM

This block is the video memory of a display subsystem. Its physical store is three quarters of a power-of-two address window, and any address is folded onto it. The window repeats across the whole incoming address space. Inside one window the lower three quarters map directly. The top quarter reuses the quarter just below it. A single bus port carries byte, halfword and word reads and writes in little-endian order. Read data is registered, so it appears one cycle after the request.

Byte stores follow a policy that depends on a 3-bit background mode input. A byte store never changes a single byte. Its value is copied into both bytes of the aligned halfword that holds the addressed byte. A byte store that lands in the object-tile area is discarded. Where that area starts depends on the mode: at half the window in modes 0 to 2, and at five eighths of the window in every other mode. Halfword and word stores are never filtered.

The window size is set by `ADDR_W`. The full-size instance uses `ADDR_W = 17`, which gives a 128 KiB window over 96 KiB of storage, an object-area start of 0x10000 or 0x14000, and a mirror of 0x18000–0x1FFFF onto 0x10000–0x17FFF. The default of 10 is a scaled copy of the same map: a 1 KiB window, 768 bytes of storage, object-area starts of 0x200 or 0x280, and a mirror of 0x300–0x3FF onto 0x200–0x2FF.

Top module: `vram_mirror`

## Requirements
- R1: While reset is asserted and after it is released, `rd_data` is 0, and every location reads as zero until it is written.
- R2: Address bits at and above `ADDR_W` are ignored, so the map repeats every 2^ADDR_W bytes.
- R3: A reduced address below 3·2^ADDR_W/4 maps to itself. Any higher reduced address maps to 2^(ADDR_W-1) plus its low ADDR_W-2 bits.
- R4: Reads return little-endian data, zero-extended to 32 bits, for `bus_size` 0 = byte, 1 = halfword, and 2 or 3 = word. A byte read takes the lane given by address bits 1:0. A halfword read ignores bit 0. A word read ignores bits 1:0.
- R5: Halfword and word writes store their data little-endian at the halfword-aligned or word-aligned mapped address.
- R6: A byte write stores its value in both bytes of the halfword-aligned mapped address.
- R7: In modes 0, 1 and 2, a byte write whose mapped address is at or above 2^(ADDR_W-1) changes nothing.
- R8: In modes 3 to 7, a byte write whose mapped address is at or above 5·2^ADDR_W/8 changes nothing.
- R9: A read issued with `bus_we` = 0 presents its data on `rd_data` in the next cycle. During a write cycle `rd_data` keeps its value.
- R10: Halfword and word writes take effect in every mode, including inside the object-tile area.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | IN_W | Byte address of the access |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2/3 word |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_wdata | input | 32 | Write data, right-aligned |
| bg_mode | input | 3 | Current background mode |
| rd_data | output | 32 | Registered, zero-extended read data |

## Verification
The assertions assume that every cycle is either a read or a write, so the bus must carry a defined size, mode and write-enable on every clock. They also assume that the mode is valid in the same cycle as a byte store. The stimulus changes all inputs only on the falling edge and holds them steady through the following rising edge. Its addresses range across the full 32-bit space, and it drives all eight mode values and all four size codes. This keeps it within those assumptions while still reaching the folded quarter and both object-area boundaries.

// File: rtl/vram_pkg.sv
package vram_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_WIDE = 2'd3
  } acc_size_e;

  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  // Pick the addressed byte or halfword out of a stored word and zero-extend it.
  function automatic logic [DATA_W-1:0] extract_read(acc_size_e sz, logic [1:0] lo,
                                                     logic [DATA_W-1:0] word);
    logic [DATA_W-1:0] res;
    res = '0;
    unique case (sz)
      SZ_BYTE: res[7:0]  = word[8*lo +: 8];
      SZ_HALF: res[15:0] = lo[1] ? word[31:16] : word[15:0];
      default: res       = word;
    endcase
    return res;
  endfunction

endpackage

// File: rtl/vram_addr_map.sv
module vram_addr_map #(
  parameter int ADDR_W = 10
) (
  input  logic [ADDR_W-1:0] red_addr,
  input  logic              is_byte,
  input  logic [2:0]        bg_mode,
  output logic [ADDR_W-1:0] phys,
  output logic              drop
);
  localparam int unsigned WIN        = 1 << ADDR_W;
  localparam int unsigned PHYS_BYTES = (3 * WIN) / 4;
  localparam int unsigned OBJ_LO     = WIN / 2;
  localparam int unsigned OBJ_HI     = (5 * WIN) / 8;
  localparam logic [ADDR_W-1:0] PHYS_L  = ADDR_W'(PHYS_BYTES);
  localparam logic [ADDR_W-1:0] OBJ_LO_L = ADDR_W'(OBJ_LO);
  localparam logic [ADDR_W-1:0] OBJ_HI_L = ADDR_W'(OBJ_HI);

  logic              folded;
  logic [ADDR_W-1:0] bound;

  always_comb begin
    folded = (red_addr >= PHYS_L);
    // The top quarter reuses the quarter that starts at half the window.
    phys   = folded ? {2'b10, red_addr[ADDR_W-3:0]} : red_addr;
    bound  = (bg_mode <= 3'd2) ? OBJ_LO_L : OBJ_HI_L;
    drop   = is_byte && (phys >= bound);
  end

endmodule

// File: rtl/vram_wr_format.sv
module vram_wr_format
  import vram_pkg::*;
(
  input  acc_size_e          sz,
  input  logic               half_sel,
  input  logic [DATA_W-1:0]  wdata,
  output logic [LANES-1:0]   lanes,
  output logic [DATA_W-1:0]  wword
);
  always_comb begin
    unique case (sz)
      SZ_BYTE: begin
        wword = {4{wdata[7:0]}};
        lanes = half_sel ? 4'b1100 : 4'b0011;
      end
      SZ_HALF: begin
        wword = {2{wdata[15:0]}};
        lanes = half_sel ? 4'b1100 : 4'b0011;
      end
      default: begin
        wword = wdata;
        lanes = 4'b1111;
      end
    endcase
  end

endmodule

// File: rtl/vram_store.sv
module vram_store
  import vram_pkg::*;
#(
  parameter int WORDS = 192,
  parameter int IDX_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [LANES-1:0]  lanes,
  input  logic [IDX_W-1:0]  idx,
  input  logic [DATA_W-1:0] wword,
  output logic [DATA_W-1:0] rword
);
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [7:0] bank [WORDS];
    logic       lane_en;

    assign lane_en = we && lanes[l];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int w = 0; w < WORDS; w++) bank[w] <= 8'h00;
      end else if (lane_en) begin
        bank[idx] <= wword[8*l +: 8];
      end
    end

    assign rword[8*l +: 8] = bank[idx];
  end

endmodule

// File: rtl/vram_mirror.sv
module vram_mirror
  import vram_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IN_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IN_W-1:0]   bus_addr,
  input  logic [1:0]        bus_size,
  input  logic              bus_we,
  input  logic [31:0]       bus_wdata,
  input  logic [2:0]        bg_mode,
  output logic [31:0]       rd_data
);
  localparam int WORDS = (3 * (1 << ADDR_W)) / 16;
  localparam int IDX_W = ADDR_W - 2;

  acc_size_e         sz;
  logic [ADDR_W-1:0] map_phys;
  logic              map_drop;
  logic              store_we;
  logic [LANES-1:0]  wr_lanes;
  logic [31:0]       wr_word;
  logic [31:0]       rd_word;
  logic [31:0]       rd_next;
  logic [31:0]       rd_q;
  logic              rd_en;

  assign sz = acc_size_e'(bus_size);

  vram_addr_map #(.ADDR_W(ADDR_W)) u_map (
    .red_addr (bus_addr[ADDR_W-1:0]),
    .is_byte  (sz == SZ_BYTE),
    .bg_mode  (bg_mode),
    .phys     (map_phys),
    .drop     (map_drop)
  );

  vram_wr_format u_fmt (
    .sz       (sz),
    .half_sel (map_phys[1]),
    .wdata    (bus_wdata),
    .lanes    (wr_lanes),
    .wword    (wr_word)
  );

  assign store_we = bus_we && !map_drop;

  vram_store #(.WORDS(WORDS), .IDX_W(IDX_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (store_we),
    .lanes (wr_lanes),
    .idx   (map_phys[ADDR_W-1:2]),
    .wword (wr_word),
    .rword (rd_word)
  );

  // Next-state logic for the read register
  always_comb begin
    rd_en   = !bus_we;
    rd_next = extract_read(sz, map_phys[1:0], rd_word);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     rd_q <= '0;
    else if (rd_en) rd_q <= rd_next;
  end

  assign rd_data = rd_q;

endmodule

// File: rtl/vram_mirror_chk.sv
module vram_mirror_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_we,
  input logic [1:0]        bus_size,
  input logic [2:0]        bg_mode,
  input logic [31:0]       rd_data,
  input logic [ADDR_W-1:0] phys_addr,
  input logic              store_we
);
  localparam logic [ADDR_W-1:0] PHYS_L   = ADDR_W'((3 * (1 << ADDR_W)) / 4);
  localparam logic [ADDR_W-1:0] OBJ_LO_L = ADDR_W'((1 << ADDR_W) / 2);
  localparam logic [ADDR_W-1:0] OBJ_HI_L = ADDR_W'((5 * (1 << ADDR_W)) / 8);

  AST_PHYS_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr < PHYS_L); // R3

  AST_BYTE_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && bus_size == 2'd0) |=> (rd_data[31:8] == 24'd0)); // R4

  AST_HALF_ZEXT: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_we && bus_size == 2'd1) |=> (rd_data[31:16] == 16'd0)); // R4

  AST_HOLD_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    bus_we |=> $stable(rd_data)); // R9

  AST_LOW_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_size == 2'd0 && bg_mode <= 3'd2 && phys_addr >= OBJ_LO_L) |-> !store_we); // R7

  AST_HIGH_MODE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_size == 2'd0 && bg_mode > 3'd2 && phys_addr >= OBJ_HI_L) |-> !store_we); // R8

  AST_WIDE_WRITE_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_we && bus_size != 2'd0) |-> store_we); // R10

endmodule

bind vram_mirror vram_mirror_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_we    (bus_we),
  .bus_size  (bus_size),
  .bg_mode   (bg_mode),
  .rd_data   (rd_data),
  .phys_addr (map_phys),
  .store_we  (store_we)
);

// File: tb/vram_mirror_bench.sv
`timescale 1ns/1ps
module vram_mirror_bench;
  localparam int ADDR_W = 10;
  localparam int WIN    = 1 << ADDR_W;
  localparam int PHYS   = (3 * WIN) / 4;
  localparam int OBJ_LO = WIN / 2;
  localparam int OBJ_HI = (5 * WIN) / 8;

  typedef struct {
    logic [31:0] exp;
    string       tag;
  } item_t;

  logic        clk;
  logic        rst_n;
  logic [31:0] bus_addr;
  logic [1:0]  bus_size;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [2:0]  bg_mode;
  logic [31:0] rd_data;

  int          checks;
  int          failures;
  bit          done;
  item_t       sb_q[$];
  logic [7:0]  mdl [PHYS];
  logic [31:0] last_rd;

  vram_mirror #(.ADDR_W(ADDR_W), .IN_W(32)) u_vram_mirror (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_size(bus_size),
    .bus_we(bus_we), .bus_wdata(bus_wdata), .bg_mode(bg_mode), .rd_data(rd_data)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  function automatic int fold(logic [31:0] a);
    int r;
    r = int'(a) & (WIN - 1);
    if (r < PHYS) return r;
    return OBJ_LO + (r & (WIN / 4 - 1));
  endfunction

  function automatic logic [31:0] model_read(logic [31:0] a, logic [1:0] sz);
    int p;
    int b;
    p = fold(a);
    if (sz == 2'd0) return {24'd0, mdl[p]};
    if (sz == 2'd1) begin
      b = p & ~1;
      return {16'd0, mdl[b+1], mdl[b]};
    end
    b = p & ~3;
    return {mdl[b+3], mdl[b+2], mdl[b+1], mdl[b]};
  endfunction

  // Driver: one access per cycle, inputs change on the falling edge.
  task automatic do_write(logic [31:0] a, logic [1:0] sz, logic [31:0] d,
                          logic [2:0] mode, string tag);
    int p;
    int b;
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_we = 1'b1; bus_wdata = d; bg_mode = mode;
    p = fold(a);
    if (sz == 2'd0) begin
      if (!((mode <= 3'd2 && p >= OBJ_LO) || (mode > 3'd2 && p >= OBJ_HI))) begin
        b = p & ~1;
        mdl[b] = d[7:0]; mdl[b+1] = d[7:0];
      end
    end else if (sz == 2'd1) begin
      b = p & ~1;
      mdl[b] = d[7:0]; mdl[b+1] = d[15:8];
    end else begin
      b = p & ~3;
      mdl[b] = d[7:0]; mdl[b+1] = d[15:8]; mdl[b+2] = d[23:16]; mdl[b+3] = d[31:24];
    end
    it.exp = last_rd;
    it.tag = {tag, "/R9-hold"};
    sb_q.push_back(it);
  endtask

  task automatic do_read(logic [31:0] a, logic [1:0] sz, string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a; bus_size = sz; bus_we = 1'b0; bus_wdata = 32'h0;
    it.exp  = model_read(a, sz);
    it.tag  = tag;
    last_rd = it.exp;
    sb_q.push_back(it);
  endtask

  // Monitor: the result of the access driven before a rising edge is visible just after it.
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (rst_n && sb_q.size() > 0) begin
        item_t it;
        it = sb_q.pop_front();
        checks++;
        if (rd_data !== it.exp) begin
          failures++;
          $display("FAIL %s: rd_data actual=%08h expected=%08h", it.tag, rd_data, it.exp);
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    checks = 0; failures = 0; done = 1'b0; last_rd = 32'h0;
    for (int i = 0; i < PHYS; i++) mdl[i] = 8'h00;
    rst_n = 1'b0; bus_addr = '0; bus_size = 2'd0; bus_we = 1'b0;
    bus_wdata = '0; bg_mode = 3'd0;
    repeat (3) @(negedge clk);
    checks++;
    if (rd_data !== 32'h0) begin
      failures++;
      $display("FAIL R1: rd_data in reset actual=%08h expected=00000000", rd_data);
    end
    rst_n = 1'b1;

    // R1: untouched memory reads zero
    do_read(32'h0000_0104, 2'd2, "R1");
    do_read(32'h0000_02F8, 2'd2, "R1");
    do_read(32'h0000_03FF, 2'd0, "R1");

    // R5 / R4: word store and lane reads
    do_write(32'h0000_0000, 2'd2, 32'h1122_3344, 3'd0, "R5");
    do_read(32'h0000_0000, 2'd2, "R5");
    do_read(32'h0000_0001, 2'd0, "R4");
    do_read(32'h0000_0003, 2'd0, "R4");
    do_read(32'h0000_0002, 2'd1, "R4");
    do_read(32'h0000_0003, 2'd1, "R4");
    do_read(32'h0000_0002, 2'd2, "R4");
    do_read(32'h0000_0001, 2'd3, "R4");

    // R5: halfword store with bit 0 set lands on the aligned halfword
    do_write(32'h0000_0013, 2'd1, 32'hFFFF_BEEF, 3'd0, "R5");
    do_read(32'h0000_0010, 2'd2, "R5");

    // R6: byte duplicated into the halfword
    do_write(32'h0000_0021, 2'd0, 32'h0000_005A, 3'd0, "R6");
    do_read(32'h0000_0020, 2'd2, "R6");
    do_write(32'h0000_0036, 2'd0, 32'hFFFF_FFC3, 3'd6, "R6");
    do_read(32'h0000_0034, 2'd2, "R6");

    // R10 / R3 / R2: word in the object area, seen through mirrors
    do_write(32'h0000_0200, 2'd2, 32'hCAFE_F00D, 3'd0, "R10");
    do_read(32'h0000_0200, 2'd2, "R10");
    do_read(32'h0000_0300, 2'd2, "R3");
    do_read(32'h0000_1200, 2'd2, "R2");
    do_read(32'hFFFF_FE00, 2'd2, "R2");

    // R7: low modes drop byte stores from half the window up
    do_write(32'h0000_0201, 2'd0, 32'h0000_0077, 3'd0, "R7");
    do_read(32'h0000_0200, 2'd2, "R7");
    do_write(32'h0000_01FF, 2'd0, 32'h0000_0066, 3'd2, "R7");
    do_read(32'h0000_01FE, 2'd1, "R7");

    // R8: other modes move the boundary to five eighths
    do_write(32'h0000_027F, 2'd0, 32'h0000_0044, 3'd3, "R8");
    do_read(32'h0000_027E, 2'd1, "R8");
    do_write(32'h0000_0280, 2'd0, 32'h0000_0055, 3'd5, "R8");
    do_read(32'h0000_0280, 2'd1, "R8");
    do_write(32'h0000_027F, 2'd0, 32'h0000_0099, 3'd1, "R7");
    do_read(32'h0000_027E, 2'd1, "R7");
    do_write(32'h0000_03A1, 2'd0, 32'h0000_0011, 3'd4, "R8");
    do_read(32'h0000_02A0, 2'd1, "R8");
    do_write(32'h0000_0371, 2'd0, 32'h0000_0022, 3'd7, "R8");
    do_read(32'h0000_0270, 2'd1, "R8");

    // R10 / R3: halfword into the object area via the folded quarter
    do_write(32'h0000_03C4, 2'd1, 32'h0000_1234, 3'd0, "R10");
    do_read(32'h0000_02C4, 2'd1, "R3");
    do_read(32'h0000_07C6, 2'd1, "R2");

    // R9: back-to-back write then read of the same word
    do_write(32'h0000_0040, 2'd2, 32'hA5A5_0F0F, 3'd0, "R9");
    do_read(32'h0000_0040, 2'd2, "R9");

    // Mixed sweep over the whole address space
    for (int n = 0; n < 600; n++) begin
      logic [31:0] a;
      logic [1:0]  s;
      a = $urandom;
      s = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 1) == 0)
        do_write(a, s, $urandom, 3'($urandom_range(0, 7)), "R2");
      else
        do_read(a, s, "R2");
    end

    @(negedge clk);
    bus_we = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule